// File: doc/BRIEF.md
# 64-bit Global Timer Comparator

This block is a free-running 64-bit up-counter paired with a 64-bit compare value. Both are reached through a small 32-bit register bus, so each 64-bit quantity appears as a low half and a high half. The counter advances by one on every clock while the run bit is set. The counter is never frozen for reads. Software that wants a coherent 64-bit value reads high, low, then high again, and retries if the two high reads differ.

When the comparator is enabled and the counter has reached or passed the compare value, the block raises a sticky event flag. Software clears the flag by writing one to it. The flag, gated by the interrupt enable, drives a level output. A one-cycle pulse marks each rising edge of that level. In auto-reload mode every match advances the compare value by a programmable 32-bit step, carried across the full 64 bits. This gives a periodic interrupt without software rewriting the compare value.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset every register reads 0, and both `irq_level` and `irq_pulse` are low.
- R2: While control bit 0 (run) is 1, the counter increases by exactly one per clock. The carry moves from the low half into the high half, and the counter wraps from all ones to zero.
- R3: While run is 0 the counter holds its value and no match event is raised, even when the comparator is enabled and the counter is at or past the compare value.
- R4: Writes to offset 0 (counter low) or offset 1 (counter high) load that half only while run is 0. While run is 1 such writes are ignored and counting continues undisturbed.
- R5: The register map uses word offsets 0 counter low, 1 counter high, 2 control, 3 status, 4 compare low, 5 compare high and 6 step. Control, compare and step read back what was written. Control keeps bits 3:0 and the other bits read 0. Offset 7 reads 0.
- R6: A match is the condition run=1, control bit 1 (comparator enable)=1 and counter >= compare. A match sets status bit 0 on the following clock, whatever the interrupt enable is.
- R7: Setting the comparator enable while the counter is below the compare value raises no event until the counter reaches that value.
- R8: Writing status with bit 0 = 1 clears the event flag. Writing bit 0 = 0 leaves it unchanged. The flag otherwise stays set until cleared.
- R9: `irq_level` equals the event flag ANDed with control bit 2 (interrupt enable). `irq_pulse` is high for exactly one clock at each rising edge of `irq_level`, so it fires once per match that has been cleared in between.
- R10: With control bit 3 (auto reload) set, each match adds the zero-extended 32-bit step to the 64-bit compare value, with the carry passing into the high half. A bus write to either compare half in the same cycle takes priority over the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_level | output | 1 | Event flag gated by interrupt enable |
| irq_pulse | output | 1 | One-clock pulse on each rising edge of `irq_level` |

## Verification
The bench drives the counter across the carry from the low half into the high half, and across the full 64-bit wrap. A design with a 32-bit adder or a missing carry would read back the wrong high half. It writes the counter while it runs and while it is stopped. A design that did not gate loads would show the written value instead of the count. It enables the comparator with the counter both above and below the compare value. An equality-only comparator would then never fire, and one that ignored the enable timing would fire early. It also checks the auto-reload sequence, including a compare value that crosses 2^32, and counts interrupt pulses around write-one-to-clear, so a repeated, missing or level-style pulse changes the count.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;

  // Word offsets on the register bus.
  localparam int OFS_CNT_LO = 0;
  localparam int OFS_CNT_HI = 1;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_STAT   = 3;
  localparam int OFS_CMP_LO = 4;
  localparam int OFS_CMP_HI = 5;
  localparam int OFS_STEP   = 6;

  // Number of implemented control bits.
  localparam int CTL_W = 4;

  // Control register layout, bit 0 at the bottom.
  typedef struct packed {
    logic auto_rel;  // bit 3
    logic irq_en;    // bit 2
    logic cmp_en;    // bit 1
    logic run;       // bit 0
  } ctrl_t;

endpackage

// File: rtl/gtimer_counter.sv
module gtimer_counter #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  ld_lo,
  input  logic                  ld_hi,
  input  logic [HALF_W-1:0]     ld_data,
  output logic [2*HALF_W-1:0]   cnt
);
  localparam int FULL_W = 2 * HALF_W;

  function automatic logic [FULL_W-1:0] bump(input logic [FULL_W-1:0] v);
    return v + FULL_W'(1);
  endfunction

  // Loads only pass while stopped.
  logic ld_lo_ok, ld_hi_ok;
  assign ld_lo_ok = ld_lo & ~run;
  assign ld_hi_ok = ld_hi & ~run;

  logic [FULL_W-1:0] cnt_nxt;
  always_comb begin
    cnt_nxt = run ? bump(cnt) : cnt;
    if (ld_lo_ok) cnt_nxt[HALF_W-1:0]      = ld_data;
    if (ld_hi_ok) cnt_nxt[FULL_W-1:HALF_W] = ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == bump($past(cnt)));

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

  p_load_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ld_lo || ld_hi)) |=> cnt == bump($past(cnt)));

endmodule

// File: rtl/gtimer_match.sv
module gtimer_match #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  cmp_en,
  input  logic                  auto_rel,
  input  logic [2*HALF_W-1:0]   cnt,
  input  logic                  wr_cmp_lo,
  input  logic                  wr_cmp_hi,
  input  logic                  wr_step,
  input  logic                  clr_req,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   cmp,
  output logic [HALF_W-1:0]     step,
  output logic                  evt_flag
);
  localparam int FULL_W = 2 * HALF_W;

  function automatic logic reached(input logic [FULL_W-1:0] c,
                                   input logic [FULL_W-1:0] target);
    return c >= target;
  endfunction

  function automatic logic [FULL_W-1:0] advance(input logic [FULL_W-1:0] target,
                                                input logic [HALF_W-1:0] inc);
    return target + {{HALF_W{1'b0}}, inc};
  endfunction

  // Named match event for the checks below.
  logic hit;
  assign hit = run & cmp_en & reached(cnt, cmp);

  logic cmp_wr_any;
  assign cmp_wr_any = wr_cmp_lo | wr_cmp_hi;

  logic [FULL_W-1:0] cmp_nxt;
  always_comb begin
    cmp_nxt = cmp;
    if (cmp_wr_any) begin
      if (wr_cmp_lo) cmp_nxt[HALF_W-1:0]      = wdata;
      if (wr_cmp_hi) cmp_nxt[FULL_W-1:HALF_W] = wdata;
    end else if (hit && auto_rel) begin
      cmp_nxt = advance(cmp, step);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp      <= '0;
      step     <= '0;
      evt_flag <= 1'b0;
    end else begin
      cmp <= cmp_nxt;
      if (wr_step) step <= wdata;
      if (hit)          evt_flag <= 1'b1;
      else if (clr_req) evt_flag <= 1'b0;
    end
  end

  p_event_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt_flag);

  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_rel && !cmp_wr_any) |=>
      cmp == $past(cmp) + {{HALF_W{1'b0}}, $past(step)});

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit) |=> !evt_flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !clr_req) |=> evt_flag);

endmodule

// File: rtl/gtimer_irq.sv
module gtimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_flag,
  input  logic irq_en,
  output logic irq_level,
  output logic irq_pulse
);
  logic level_q;

  assign irq_level = evt_flag & irq_en;
  assign irq_pulse = irq_level & ~level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= irq_level;
  end

  p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  p_pulse_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (evt_flag && irq_en));

endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
  import gtimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_level,
  output logic              irq_pulse
);
  localparam int FULL_W = 2 * DATA_W;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // Write decode.
  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;
  assign wr_cnt_lo = bus_wr & sel(bus_addr, OFS_CNT_LO);
  assign wr_cnt_hi = bus_wr & sel(bus_addr, OFS_CNT_HI);
  assign wr_ctrl   = bus_wr & sel(bus_addr, OFS_CTRL);
  assign wr_stat   = bus_wr & sel(bus_addr, OFS_STAT);
  assign wr_cmp_lo = bus_wr & sel(bus_addr, OFS_CMP_LO);
  assign wr_cmp_hi = bus_wr & sel(bus_addr, OFS_CMP_HI);
  assign wr_step   = bus_wr & sel(bus_addr, OFS_STEP);

  logic clr_req;
  assign clr_req = wr_stat & bus_wdata[0];

  ctrl_t ctrl_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTL_W-1:0]);
  end

  logic [FULL_W-1:0] cnt;
  logic [FULL_W-1:0] cmp;
  logic [DATA_W-1:0] step;
  logic              evt_flag;

  gtimer_counter #(.HALF_W(DATA_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .ld_lo   (wr_cnt_lo),
    .ld_hi   (wr_cnt_hi),
    .ld_data (bus_wdata),
    .cnt     (cnt)
  );

  gtimer_match #(.HALF_W(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .cmp_en    (ctrl_q.cmp_en),
    .auto_rel  (ctrl_q.auto_rel),
    .cnt       (cnt),
    .wr_cmp_lo (wr_cmp_lo),
    .wr_cmp_hi (wr_cmp_hi),
    .wr_step   (wr_step),
    .clr_req   (clr_req),
    .wdata     (bus_wdata),
    .cmp       (cmp),
    .step      (step),
    .evt_flag  (evt_flag)
  );

  gtimer_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_flag  (evt_flag),
    .irq_en    (ctrl_q.irq_en),
    .irq_level (irq_level),
    .irq_pulse (irq_pulse)
  );

  // Live read mux: the counter is never snapshotted.
  always_comb begin
    bus_rdata = '0;
    if      (sel(bus_addr, OFS_CNT_LO)) bus_rdata = cnt[DATA_W-1:0];
    else if (sel(bus_addr, OFS_CNT_HI)) bus_rdata = cnt[FULL_W-1:DATA_W];
    else if (sel(bus_addr, OFS_CTRL))   bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctrl_q};
    else if (sel(bus_addr, OFS_STAT))   bus_rdata = {{(DATA_W-1){1'b0}}, evt_flag};
    else if (sel(bus_addr, OFS_CMP_LO)) bus_rdata = cmp[DATA_W-1:0];
    else if (sel(bus_addr, OFS_CMP_HI)) bus_rdata = cmp[FULL_W-1:DATA_W];
    else if (sel(bus_addr, OFS_STEP))   bus_rdata = step;
  end

  p_stopped_no_new_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !evt_flag) |=> !evt_flag);

  p_irq_off_without_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq_level);

endmodule

// File: tb/tb_gtimer_cmp.sv
`timescale 1ns/1ps
module tb_gtimer_cmp;

  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_CTL = 3'd2, A_ST = 3'd3,
                         A_MLO = 3'd4, A_MHI = 3'd5, A_STP = 3'd6, A_NONE = 3'd7;
  localparam logic OP_WR = 1'b0, OP_RD = 1'b1;
  localparam int WATCHDOG_CYC = 200000;

  typedef struct packed {
    logic        op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, A_CTL, 32'h0, 32'h0, 4'd1},                // R1 control after reset
    '{OP_RD, A_ST,  32'h0, 32'h0, 4'd1},                // R1 status after reset
    '{OP_RD, A_CLO, 32'h0, 32'h0, 4'd1},                // R1 counter after reset
    '{OP_RD, A_MHI, 32'h0, 32'h0, 4'd1},                // R1 compare after reset
    '{OP_WR, A_CLO, 32'hFFFF_FFFE, 32'h0, 4'd0},
    '{OP_WR, A_CHI, 32'h0000_0001, 32'h0, 4'd0},
    '{OP_RD, A_CLO, 32'h0, 32'hFFFF_FFFE, 4'd4},        // R4 load while stopped
    '{OP_RD, A_CHI, 32'h0, 32'h0000_0001, 4'd4},        // R4
    '{OP_WR, A_CTL, 32'h1, 32'h0, 4'd0},                // run
    '{OP_RD, A_ST,  32'h0, 32'h0, 4'd6},                // R6 no event without comparator
    '{OP_WR, A_CTL, 32'h0, 32'h0, 4'd0},                // stop: two counts elapsed
    '{OP_RD, A_CLO, 32'h0, 32'h0, 4'd2},                // R2 low half carry out
    '{OP_RD, A_CHI, 32'h0, 32'h2, 4'd2},                // R2 carry into high half
    '{OP_WR, A_CTL, 32'h1, 32'h0, 4'd0},
    '{OP_WR, A_CLO, 32'h1234, 32'h0, 4'd0},             // ignored, running
    '{OP_WR, A_CTL, 32'h0, 32'h0, 4'd0},
    '{OP_RD, A_CLO, 32'h0, 32'h2, 4'd4},                // R4 write while running dropped
    '{OP_RD, A_CHI, 32'h0, 32'h2, 4'd4},                // R4
    '{OP_WR, A_CLO, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{OP_WR, A_CHI, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{OP_WR, A_CTL, 32'h1, 32'h0, 4'd0},
    '{OP_RD, A_CTL, 32'h0, 32'h1, 4'd5},                // R5 control readback
    '{OP_WR, A_CTL, 32'h0, 32'h0, 4'd0},
    '{OP_RD, A_CLO, 32'h0, 32'h1, 4'd2},                // R2 64-bit wrap
    '{OP_RD, A_CHI, 32'h0, 32'h0, 4'd2},                // R2
    '{OP_WR, A_STP, 32'h0000_ABCD, 32'h0, 4'd0},
    '{OP_RD, A_STP, 32'h0, 32'h0000_ABCD, 4'd5},        // R5 step readback
    '{OP_WR, A_MLO, 32'h0000_0055, 32'h0, 4'd0},
    '{OP_RD, A_MLO, 32'h0, 32'h0000_0055, 4'd5},        // R5 compare low
    '{OP_WR, A_MHI, 32'h0000_0007, 32'h0, 4'd0},
    '{OP_RD, A_MHI, 32'h0, 32'h0000_0007, 4'd5},        // R5 compare high
    '{OP_WR, A_CTL, 32'hFFFF_FFF0, 32'h0, 4'd0},        // only bits 3:0 kept
    '{OP_RD, A_CTL, 32'h0, 32'h0, 4'd5}                 // R5 upper control bits read 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_level, irq_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  gtimer_cmp dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_level (irq_level),
    .irq_pulse (irq_pulse)
  );

  always @(negedge clk) if (rst_n && irq_pulse) pulses++;

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  // Each bus operation starts on a falling edge and takes one clock.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bus_wr = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(1, {30'd0, irq_level, irq_pulse}, 32'h0);    // R1 outputs low after reset
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == OP_WR) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        chk(int'(VECS[i].req), v, VECS[i].exp);
      end
    end

    // R3: stopped counter holds; no event while stopped even past compare.
    wr(A_CTL, 32'h0);
    idle(10);
    rd(A_CLO, v); chk(3, v, 32'h1);
    wr(A_MLO, 32'h0); wr(A_MHI, 32'h0);
    wr(A_CTL, 32'h6);
    idle(5);
    rd(A_ST, v); chk(3, v, 32'h0);
    chk(3, {31'd0, irq_level}, 32'h0);

    // R6: counter already past compare, start running: event without irq enable.
    wr(A_CTL, 32'h3);
    idle(3);
    rd(A_ST, v); chk(6, v, 32'h1);
    chk(6, {31'd0, irq_level}, 32'h0);

    // R8: write 0 keeps flag, write 1 clears it.
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk(8, v, 32'h1);
    wr(A_CTL, 32'h0);
    wr(A_ST, 32'h1);
    rd(A_ST, v); chk(8, v, 32'h0);

    // R7: comparator enabled below compare value stays quiet.
    wr(A_CLO, 32'h0); wr(A_CHI, 32'h0);
    wr(A_MLO, 32'd1000); wr(A_MHI, 32'h0);
    wr(A_STP, 32'h0);
    wr(A_CTL, 32'h3);
    idle(20);
    rd(A_ST, v); chk(7, v, 32'h0);
    idle(1000);
    rd(A_ST, v); chk(6, v, 32'h1);
    chk(9, {31'd0, irq_level}, 32'h0);

    // R9: enabling irq with flag set yields a level and a single pulse.
    base = pulses;
    wr(A_CTL, 32'h7);
    idle(2);
    chk(9, {31'd0, irq_level}, 32'h1);
    chk(9, pulses - base, 1);
    idle(5);
    chk(9, pulses - base, 1);

    // R10: periodic reload by the step.
    wr(A_CTL, 32'h0);
    wr(A_ST, 32'h1);
    wr(A_CLO, 32'h0); wr(A_CHI, 32'h0);
    wr(A_MLO, 32'd20); wr(A_MHI, 32'h0);
    wr(A_STP, 32'd50);
    base = pulses;
    wr(A_CTL, 32'hF);
    idle(40);
    rd(A_MLO, v); chk(10, v, 32'd70);
    rd(A_ST, v);  chk(10, v, 32'h1);
    chk(9, pulses - base, 1);
    wr(A_ST, 32'h1);
    rd(A_ST, v);  chk(8, v, 32'h0);
    idle(50);
    rd(A_MLO, v); chk(10, v, 32'd120);
    rd(A_ST, v);  chk(10, v, 32'h1);
    chk(9, pulses - base, 2);

    // R10: reload carries into the compare high half.
    wr(A_CTL, 32'h0);
    wr(A_CLO, 32'hFFFF_FFE0); wr(A_CHI, 32'h0);
    wr(A_MLO, 32'hFFFF_FFF0); wr(A_MHI, 32'h0);
    wr(A_STP, 32'h20);
    wr(A_CTL, 32'hB);
    idle(30);
    rd(A_MHI, v); chk(10, v, 32'h1);
    rd(A_MLO, v); chk(10, v, 32'h10);
    rd(A_CHI, v); chk(2, v, 32'h1);

    summary();
    $finish;
  end

endmodule